// File: doc/BRIEF.md
# Row Accumulator with Tanh Activation

This block closes one row of a processing-element grid in which each row evaluates one neuron. Every cycle it may accept one set of signed partial products, one from each element of the row, and add them into a wide signed sum. The sum is scaled down by a fixed arithmetic right shift and clamped into the signed 8-bit range. The clamped value then addresses a hyperbolic-tangent table. Each activated 8-bit neuron output is offered on a valid/ready result port and is also stored in a small register bank.

The bank connects the row to two 8-bit buses shared between rows. Under a select input, the row either drives one stored entry onto its outgoing bus or captures a value from the incoming bus into a chosen entry. This is how hidden-layer results travel back into the grid to compute the output layer. A stall at the result port propagates back to the partial-sum input, so no result is dropped.

Top module: `row_accumulator`

## Requirements
- R1: After reset, act_valid is 0, bus_out is 0, bus_out_valid is 0, psum_ready is 1, and every bank entry reads back as 0.
- R2: The sum is the exact two's-complement total of the N_PE partial sums packed in psum_in, lane i in bits [i*PSUM_W +: PSUM_W], each PSUM_W = 29 bits wide. The accumulator is 32 bits wide and does not overflow for four lanes at full scale.
- R3: The truncated state is the sum shifted arithmetically right by SHIFT = 10 bits, which rounds toward minus infinity. Values above 127 clamp to 127 and values below -128 clamp to -128, with no wrap-around.
- R4: For truncated state s, act_data equals 127*tanh(s/32) rounded to the nearest integer, with halves rounded away from zero, as an 8-bit two's-complement value. As a consequence, the code for -s is the negation of the code for s, and the code for 0 is 0.
- R5: When psum_valid and psum_ready are both high at clock edge t, the result is shown with act_valid high after edge t+1 and not before.
- R6: While act_valid is high and act_ready is low, act_valid stays high and act_data is unchanged. With both pipeline stages full, psum_ready is low.
- R7: Each accepted result (act_valid and act_ready high at an edge) is written to the bank entry given by a write pointer. The pointer starts at 0 after reset and advances by one per accepted result, returning to 0 after entry BANK_DEPTH-1 = 3.
- R8: The bus_mode encoding is 0 idle, 1 drive, 2 capture, and 3 treated as idle. If bus_mode is 1 at an edge, bus_out holds the entry selected by bus_idx and bus_out_valid is 1 after that edge. For any other mode, both read 0 after the edge.
- R9: If bus_mode is 2 at an edge, bus_in is written into the entry selected by bus_idx, and the write pointer does not move. When a capture and a result write hit the same entry in one cycle, the captured value is kept, and the pointer still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psum_in | input | N_PE*PSUM_W (116) | Packed signed partial sums, lane 0 in the low bits |
| psum_valid | input | 1 | Partial sums present |
| psum_ready | output | 1 | Row can accept partial sums |
| act_data | output | STATE_W (8) | Activated neuron output |
| act_valid | output | 1 | act_data holds a new result |
| act_ready | input | 1 | Consumer takes the result |
| bus_mode | input | 2 | 0 idle, 1 drive, 2 capture, 3 idle |
| bus_idx | input | log2(BANK_DEPTH) (2) | Bank entry for drive or capture |
| bus_in | input | STATE_W (8) | Value arriving from another row |
| bus_out | output | STATE_W (8) | Value leaving for other rows, 0 when not driving |
| bus_out_valid | output | 1 | bus_out carries a driven entry |

## Verification
A wrong sum, shift or clamp shows at act_data two edges after the partial sums are accepted. The full sweep of table indices exposes any such error, and so do the clamp-boundary sums that sit one count on either side of ±128. A wrong table entry shows the same way, and any loss of sign symmetry appears when results for s and -s are compared. Bank errors, such as a pointer that skips or fails to wrap, a capture that loses to a result write, or a bus that is not quiet when idle, appear on bus_out one edge after a drive request.

// File: rtl/rowacc_pkg.sv
package rowacc_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE    = 2'd0,
    BUS_DRIVE   = 2'd1,
    BUS_CAPTURE = 2'd2,
    BUS_RSVD    = 2'd3
  } bus_mode_e;

  // Activation code for signed state s: out_max*tanh(s / 2^in_frac),
  // rounded to nearest with halves away from zero.
  function automatic int tanh_code(input int s, input int in_frac, input int out_max);
    real x;
    real y;
    int  r;
    x = real'(s) / real'(1 << in_frac);
    y = real'(out_max) * $tanh(x);
    if (y >= 0.0) r = $rtoi(y + 0.5);
    else          r = -$rtoi(-y + 0.5);
    return r;
  endfunction

endpackage

// File: rtl/rowacc_reduce.sv
module rowacc_reduce #(
  parameter int N_PE   = 4,
  parameter int PSUM_W = 29,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_PE*PSUM_W-1:0]   lanes,
  input  logic                     in_valid,
  output logic                     in_ready,
  output logic signed [ACC_W-1:0]  sum_q,
  output logic                     out_valid,
  input  logic                     out_ready
);

  logic signed [ACC_W-1:0] ext [N_PE];
  logic signed [ACC_W-1:0] total;

  genvar g;
  generate
    for (g = 0; g < N_PE; g++) begin : g_lane
      logic signed [PSUM_W-1:0] lane_v;
      assign lane_v = lanes[g*PSUM_W +: PSUM_W];
      assign ext[g] = ACC_W'(lane_v);
    end
  endgenerate

  always_comb begin
    total = '0;
    for (int i = 0; i < N_PE; i++) total = total + ext[i];
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      sum_q     <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) sum_q <= total;
    end
  end

  // R2: an accepted set of partials is present in the stage on the next cycle
  a_r2_stage_loaded: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R6: a stalled stage keeps its sum
  a_r6_sum_held: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(sum_q)));

endmodule

// File: rtl/rowacc_act.sv
module rowacc_act #(
  parameter int ACC_W   = 32,
  parameter int STATE_W = 8,
  parameter int SHIFT   = 10,
  parameter int IN_FRAC = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [ACC_W-1:0]  in_sum,
  input  logic                     in_valid,
  output logic                     in_ready,
  output logic [STATE_W-1:0]       out_data,
  output logic                     out_valid,
  input  logic                     out_ready
);

  localparam int LUT_N   = 1 << STATE_W;
  localparam int OUT_MAX = (1 << (STATE_W - 1)) - 1;
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'(OUT_MAX);
  localparam logic signed [ACC_W-1:0] SAT_LO = -ACC_W'(OUT_MAX + 1);

  logic signed [ACC_W-1:0] shifted;
  logic [STATE_W-1:0]      state_idx;
  logic                    load;

  logic [STATE_W-1:0] rom [LUT_N];

  initial begin
    for (int i = 0; i < LUT_N; i++) begin
      int sv;
      int code;
      sv   = (i >= LUT_N / 2) ? i - LUT_N : i;
      code = rowacc_pkg::tanh_code(sv, IN_FRAC, OUT_MAX);
      rom[i] = code[STATE_W-1:0];
    end
  end

  always_comb begin
    shifted = in_sum >>> SHIFT;
    if (shifted > SAT_HI)      state_idx = SAT_HI[STATE_W-1:0];
    else if (shifted < SAT_LO) state_idx = SAT_LO[STATE_W-1:0];
    else                       state_idx = shifted[STATE_W-1:0];
  end

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  // table read, registered with enable
  always_ff @(posedge clk) begin
    if (load) out_data <= rom[state_idx];
  end

  always_ff @(posedge clk) begin
    if (rst)           out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  // R4: a zero state always yields a zero code
  a_r4_zero_maps_zero: assert property (@(posedge clk) disable iff (rst)
    (load && state_idx == '0) |=> (out_data == '0));

  // R3: a sum far above the range lands on the top code
  a_r3_clamp_high: assert property (@(posedge clk) disable iff (rst)
    (load && shifted > SAT_HI) |=> (out_data == rom[OUT_MAX]));

  // R6: stalled result stays put
  a_r6_result_held: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/rowacc_bank.sv
module rowacc_bank #(
  parameter int DEPTH   = 4,
  parameter int STATE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [STATE_W-1:0]        wr_data,
  input  logic [1:0]                mode,
  input  logic [$clog2(DEPTH)-1:0]  idx,
  input  logic [STATE_W-1:0]        bus_in,
  output logic [STATE_W-1:0]        bus_out,
  output logic                      bus_out_valid
);

  import rowacc_pkg::*;

  localparam int PTR_W = $clog2(DEPTH);

  logic [STATE_W-1:0] entry [DEPTH];
  logic [PTR_W-1:0]   wr_ptr;
  logic               cap;
  logic               drive;

  assign cap   = (mode == BUS_CAPTURE);
  assign drive = (mode == BUS_DRIVE);

  always_ff @(posedge clk) begin
    if (rst)             wr_ptr <= '0;
    else if (wr_en) begin
      if (wr_ptr == PTR_W'(DEPTH - 1)) wr_ptr <= '0;
      else                             wr_ptr <= wr_ptr + 1'b1;
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_entry
      always_ff @(posedge clk) begin
        if (rst)                                        entry[g] <= '0;
        else if (cap && idx == PTR_W'(g))               entry[g] <= bus_in;
        else if (wr_en && wr_ptr == PTR_W'(g))          entry[g] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_out       <= '0;
      bus_out_valid <= 1'b0;
    end else begin
      bus_out       <= drive ? entry[idx] : '0;
      bus_out_valid <= drive;
    end
  end

  // R8: the outgoing bus is quiet unless a drive was requested
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode != BUS_DRIVE) |=> (bus_out == '0 && !bus_out_valid));

  // R9: a captured value is present in its entry afterwards
  a_r9_capture_lands: assert property (@(posedge clk) disable iff (rst)
    cap |=> (entry[$past(idx)] == $past(bus_in)));

  // R7: the pointer only moves on an accepted result
  a_r7_ptr_still: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(wr_ptr));

endmodule

// File: rtl/row_accumulator.sv
module row_accumulator #(
  parameter int N_PE       = 4,
  parameter int PSUM_W     = 29,
  parameter int ACC_W      = 32,
  parameter int STATE_W    = 8,
  parameter int SHIFT      = 10,
  parameter int IN_FRAC    = 5,
  parameter int BANK_DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_PE*PSUM_W-1:0]        psum_in,
  input  logic                          psum_valid,
  output logic                          psum_ready,
  output logic [STATE_W-1:0]            act_data,
  output logic                          act_valid,
  input  logic                          act_ready,
  input  logic [1:0]                    bus_mode,
  input  logic [$clog2(BANK_DEPTH)-1:0] bus_idx,
  input  logic [STATE_W-1:0]            bus_in,
  output logic [STATE_W-1:0]            bus_out,
  output logic                          bus_out_valid
);

  logic signed [ACC_W-1:0] sum_q;
  logic                    sum_valid;
  logic                    act_in_ready;
  logic                    result_fire;

  rowacc_reduce #(
    .N_PE   (N_PE),
    .PSUM_W (PSUM_W),
    .ACC_W  (ACC_W)
  ) u_reduce (
    .clk       (clk),
    .rst       (rst),
    .lanes     (psum_in),
    .in_valid  (psum_valid),
    .in_ready  (psum_ready),
    .sum_q     (sum_q),
    .out_valid (sum_valid),
    .out_ready (act_in_ready)
  );

  rowacc_act #(
    .ACC_W   (ACC_W),
    .STATE_W (STATE_W),
    .SHIFT   (SHIFT),
    .IN_FRAC (IN_FRAC)
  ) u_act (
    .clk       (clk),
    .rst       (rst),
    .in_sum    (sum_q),
    .in_valid  (sum_valid),
    .in_ready  (act_in_ready),
    .out_data  (act_data),
    .out_valid (act_valid),
    .out_ready (act_ready)
  );

  assign result_fire = act_valid && act_ready;

  rowacc_bank #(
    .DEPTH   (BANK_DEPTH),
    .STATE_W (STATE_W)
  ) u_bank (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (result_fire),
    .wr_data       (act_data),
    .mode          (bus_mode),
    .idx           (bus_idx),
    .bus_in        (bus_in),
    .bus_out       (bus_out),
    .bus_out_valid (bus_out_valid)
  );

  // R6: input is blocked only while both stages hold data
  a_r6_block_full: assert property (@(posedge clk) disable iff (rst)
    !psum_ready |-> (sum_valid && act_valid && !act_ready));

  // R5: a result never appears without an accepted input two edges back
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    $rose(act_valid) |-> $past(sum_valid));

endmodule

// File: tb/row_accumulator_tb.sv
module row_accumulator_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N_PE   = 4;
  localparam int PSUM_W = 29;
  localparam int SW     = 8;

  logic                   clk = 1'b0;
  logic                   rst;
  logic [N_PE*PSUM_W-1:0] psum_in;
  logic                   psum_valid;
  logic                   psum_ready;
  logic [SW-1:0]          act_data;
  logic                   act_valid;
  logic                   act_ready;
  logic [1:0]             bus_mode;
  logic [1:0]             bus_idx;
  logic [SW-1:0]          bus_in;
  logic [SW-1:0]          bus_out;
  logic                   bus_out_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int got [256];

  always #(CLK_PERIOD / 2) clk = ~clk;

  row_accumulator u_dut (
    .clk(clk), .rst(rst), .psum_in(psum_in), .psum_valid(psum_valid),
    .psum_ready(psum_ready), .act_data(act_data), .act_valid(act_valid),
    .act_ready(act_ready), .bus_mode(bus_mode), .bus_idx(bus_idx),
    .bus_in(bus_in), .bus_out(bus_out), .bus_out_valid(bus_out_valid)
  );

  function automatic int ref_state(input longint total);
    longint s;
    s = total >>> 10;
    if (s > 127)  return 127;
    if (s < -128) return -128;
    return int'(s);
  endfunction

  function automatic int ref_tanh(input int s);
    real y;
    y = 127.0 * $tanh(real'(s) / 32.0);
    if (y >= 0.0) return $rtoi(y + 0.5);
    return -$rtoi(0.5 - y);
  endfunction

  function automatic int s8(input logic [7:0] v);
    return int'($signed(v));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; psum_valid = 1'b0; act_ready = 1'b1;
    bus_mode = 2'd0; bus_idx = 2'd0; bus_in = '0; psum_in = '0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  // returns just after the accepting edge
  task automatic send(input int a, input int b, input int c, input int d);
    @(negedge clk);
    psum_in    = {PSUM_W'(d), PSUM_W'(c), PSUM_W'(b), PSUM_W'(a)};
    psum_valid = 1'b1;
    while (!psum_ready) @(negedge clk);
    @(posedge clk);
    #1 psum_valid = 1'b0;
  endtask

  task automatic send_check(input int a, input int b, input int c, input int d,
                            input string req, output int code);
    int exp;
    exp = ref_tanh(ref_state(longint'(a) + b + c + d));
    send(a, b, c, d);
    @(negedge clk);
    chk(act_valid == 1'b0, "R5 early", int'(act_valid), 0);
    @(negedge clk);
    chk(act_valid == 1'b1, "R5 valid", int'(act_valid), 1);
    chk(s8(act_data) == exp, req, s8(act_data), exp);
    code = s8(act_data);
  endtask

  task automatic drive_check(input int i, input int exp, input string req);
    @(negedge clk);
    bus_mode = 2'd1; bus_idx = 2'(i);
    @(negedge clk);
    chk(bus_out_valid == 1'b1, req, int'(bus_out_valid), 1);
    chk(s8(bus_out) == exp, req, s8(bus_out), exp);
    bus_mode = 2'd0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int code;
    rst = 1'b1; psum_valid = 1'b0; act_ready = 1'b1; psum_in = '0;
    bus_mode = 2'd0; bus_idx = 2'd0; bus_in = '0;
    do_reset();

    // R1 reset state
    @(negedge clk);
    chk(act_valid == 1'b0, "R1 act_valid", int'(act_valid), 0);
    chk(psum_ready == 1'b1, "R1 psum_ready", int'(psum_ready), 1);
    chk(bus_out == '0 && !bus_out_valid, "R1 bus idle", int'(bus_out), 0);
    for (int i = 0; i < 4; i++) drive_check(i, 0, "R1 bank zero");

    // R3 R4 sweep of every state value, with fractional bits below the shift
    for (int k = -128; k < 128; k++) begin
      int total;
      total = k * 1024 + ((k * 37) & 1023);
      send_check(total - 6 * k, 3 * k, 3 * k, 0, "R4 sweep", code);
      got[k + 128] = code;
    end
    chk(got[128] == 0, "R4 zero", got[128], 0);
    for (int k = 1; k < 128; k++)
      chk(got[128 + k] == -got[128 - k], "R4 symmetry", got[128 + k], -got[128 - k]);

    // R3 clamp boundaries and floor rounding
    send_check(131071, 0, 0, 0, "R3 just below top", code);
    send_check(131072, 0, 0, 0, "R3 clamp top", code);
    send_check(-131072, 0, 0, 0, "R3 bottom exact", code);
    send_check(-131073, 0, 0, 0, "R3 clamp bottom", code);
    send_check(-1, 0, 0, 0, "R3 floor -1", code);
    send_check(-1025, 0, 0, 0, "R3 floor -1025", code);
    // R2 full-scale lanes needing the wide accumulator
    send_check(268435455, 268435455, 268435455, 268435455, "R2 full positive", code);
    send_check(-268435456, -268435456, -268435456, -268435456, "R2 full negative", code);
    send_check(200000, -100000, 30000, 0, "R2 mixed lanes", code);
    send_check(268435455, -268435456, 5000, 0, "R2 cancel", code);

    // R6 backpressure
    @(negedge clk); act_ready = 1'b0;
    send(10 * 1024, 0, 0, 0);
    send(20 * 1024, 0, 0, 0);
    @(negedge clk);
    chk(psum_ready == 1'b0, "R6 blocked", int'(psum_ready), 0);
    for (int i = 0; i < 3; i++) begin
      chk(act_valid == 1'b1, "R6 hold valid", int'(act_valid), 1);
      chk(s8(act_data) == ref_tanh(10), "R6 hold data", s8(act_data), ref_tanh(10));
      @(negedge clk);
    end
    act_ready = 1'b1;
    @(negedge clk);
    chk(act_valid == 1'b1, "R6 second", int'(act_valid), 1);
    chk(s8(act_data) == ref_tanh(20), "R6 second data", s8(act_data), ref_tanh(20));
    @(negedge clk);
    chk(act_valid == 1'b0, "R6 drained", int'(act_valid), 0);

    // R7 R8 R9 bank
    do_reset();
    send_check(10 * 1024, 0, 0, 0, "R7 fill0", code);
    send_check(20 * 1024, 0, 0, 0, "R7 fill1", code);
    send_check(-30 * 1024, 0, 0, 0, "R7 fill2", code);
    send_check(40 * 1024, 0, 0, 0, "R7 fill3", code);
    @(negedge clk);
    drive_check(0, ref_tanh(10), "R7 entry0");
    drive_check(1, ref_tanh(20), "R7 entry1");
    drive_check(2, ref_tanh(-30), "R7 entry2");
    drive_check(3, ref_tanh(40), "R7 entry3");
    @(negedge clk);
    chk(bus_out == '0 && !bus_out_valid, "R8 idle after drive", int'(bus_out), 0);
    bus_mode = 2'd3; bus_idx = 2'd3;
    @(negedge clk);
    chk(bus_out == '0 && !bus_out_valid, "R8 mode3 quiet", int'(bus_out), 0);
    bus_mode = 2'd2; bus_idx = 2'd2; bus_in = 8'h5A;
    @(negedge clk);
    bus_mode = 2'd0;
    chk(bus_out == '0 && !bus_out_valid, "R8 capture quiet", int'(bus_out), 0);
    drive_check(2, 8'h5A, "R9 captured");
    drive_check(1, ref_tanh(20), "R9 neighbour intact");
    // pointer wrapped to 0 and was not moved by the capture
    send_check(50 * 1024, 0, 0, 0, "R7 wrap", code);
    @(negedge clk);
    drive_check(0, ref_tanh(50), "R7 wrap entry0");
    // capture and result write on entry 1 in the same cycle
    send(60 * 1024, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    bus_mode = 2'd2; bus_idx = 2'd1; bus_in = 8'h33;
    @(negedge clk);
    bus_mode = 2'd0;
    drive_check(1, 8'h33, "R9 capture priority");
    send_check(70 * 1024, 0, 0, 0, "R9 pointer advanced", code);
    @(negedge clk);
    drive_check(2, ref_tanh(70), "R9 next entry2");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule